// File: doc/BRIEF.md
# Byte-Masked Quadword Write Engine

This block sits between requesters that store bytes, 16-bit halves or 32-bit words and a memory that only moves whole 64-bit quadwords. A requester hands over one write at a time on a valid/ready port. Each write carries a quadword address, a 64-bit data word and an 8-bit lane mask. When the mask selects only some lanes, the engine fetches the quadword at that address and overlays the selected lanes with the new bytes. It then stores the whole quadword back to the same address. The requester takes no part once its write has been accepted.

Writes that select every lane go straight to memory as one quadword store. Writes that select no lane finish at once and touch nothing. On the memory side the engine uses a single command port with a read/write flag and a separate read-return strobe. A pulse on `wr_done` marks the end of each accepted write. The engine accepts nothing new while a sequence is running, so no other access can land between its fetch and its store-back.

Top module: `rmw_engine`

## Requirements
- R1: Every memory command carries a full quadword. Write commands drive all 64 data bits, and there is exactly one address per command.
- R2: A write whose mask is neither all-zero nor all-ones produces exactly one read command, followed by exactly one write command to the same address.
- R3: In the stored quadword, lane i (bits 8i+7 down to 8i, little-endian lane order) takes the new data when mask bit i is 1. Otherwise it keeps the value that was fetched.
- R4: All 256 mask values merge correctly, including masks whose set bits are not adjacent.
- R5: With FULL_BYPASS=1, an all-ones mask (8'hFF) produces one write command in the cycle after acceptance and no read command. With FULL_BYPASS=0, it goes through the fetch-and-merge path like any other mask.
- R6: A mask of 8'h00 raises `wr_done` in the cycle after acceptance and produces no memory command.
- R7: `req_ready` drops in the cycle after a request is accepted. It stays low through the cycle in which `wr_done` is high.
- R8: `wr_done` is a single-cycle pulse, given once for each accepted request.
- R9: While `mem_cmd_valid` is high and `mem_cmd_ready` is low, the command, its address and its write flag hold steady into the next cycle.
- R10: After reset, `req_ready` is 1 and `mem_cmd_valid` and `wr_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Engine can accept a request |
| req_addr | input | ADDR_W | Quadword address |
| req_data | input | 64 | New data, lane i in bits 8i+7:8i |
| req_be | input | 8 | Lane mask, bit i selects lane i |
| mem_cmd_valid | output | 1 | Memory command present |
| mem_cmd_ready | input | 1 | Memory takes the command |
| mem_cmd_write | output | 1 | 1 = quadword store, 0 = quadword fetch |
| mem_cmd_addr | output | ADDR_W | Command address |
| mem_wdata | output | 64 | Store data |
| mem_rdata_valid | input | 1 | Fetched quadword present |
| mem_rdata | input | 64 | Fetched quadword |
| wr_done | output | 1 | Request finished (one-cycle pulse) |

## Verification
Two things can coincide: a new request at the port, and the store-back of the sequence still running for the same quadword. The bench provokes this by holding a second request on the same address high from the cycle after the first is accepted. It uses masks that overlap the first in some lanes. It judges the result by `req_ready` staying low until `wr_done`, and by the final memory word, which must hold the second request's lanes on top of the first request's merged result. Every one of the 256 masks is swept against a bench memory model whose command port stalls periodically. The expected quadword and the read and write counts for each sweep step are computed arithmetically.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ISSUE,
      ST_RD_WAIT,
      ST_MERGE,
      ST_WR_ISSUE,
      ST_DONE
   } rmw_state_e;
endpackage

// File: rtl/rmw_lane_merge.sv
module rmw_lane_merge #(
   parameter int LANE_W    = 8,
   parameter int NUM_LANES = 8,
   localparam int DATA_W   = LANE_W * NUM_LANES
) (
   input  logic [DATA_W-1:0]    old_q,
   input  logic [DATA_W-1:0]    new_q,
   input  logic [NUM_LANES-1:0] lane_en,
   output logic [DATA_W-1:0]    merged
);
   generate
      for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
         assign merged[g*LANE_W +: LANE_W] =
            lane_en[g] ? new_q[g*LANE_W +: LANE_W] : old_q[g*LANE_W +: LANE_W];
      end
   endgenerate
endmodule

// File: rtl/rmw_qbuf.sv
module rmw_qbuf #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_req,
   input  logic              ld_rd,
   input  logic              ld_mrg,
   input  logic [DATA_W-1:0] req_data,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] mrg_data,
   output logic [DATA_W-1:0] work_q,
   output logic [DATA_W-1:0] new_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         work_q <= '0;
         new_q  <= '0;
      end else begin
         if (ld_req) begin
            work_q <= req_data;
            new_q  <= req_data;
         end else if (ld_rd) begin
            work_q <= rd_data;
         end else if (ld_mrg) begin
            work_q <= mrg_data;
         end
      end
   end
endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
   import rmw_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int NUM_LANES   = 8,
   parameter bit FULL_BYPASS = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [NUM_LANES-1:0] req_be,
   output logic [NUM_LANES-1:0] cap_be,
   output logic                 mem_cmd_valid,
   input  logic                 mem_cmd_ready,
   output logic                 mem_cmd_write,
   output logic [ADDR_W-1:0]    mem_cmd_addr,
   input  logic                 mem_rdata_valid,
   output logic                 wr_done,
   output logic                 ld_req,
   output logic                 ld_rd,
   output logic                 ld_mrg
);
   rmw_state_e st_q, st_d;
   logic [ADDR_W-1:0] addr_q;
   logic mask_none, mask_all, skip_rd;

   assign mask_none = ~|req_be;
   assign mask_all  = &req_be;

   generate
      if (FULL_BYPASS) begin : g_bypass
         assign skip_rd = mask_all;
      end else begin : g_always_rmw
         assign skip_rd = 1'b0;
      end
   endgenerate

   assign req_ready     = (st_q == ST_IDLE);
   assign ld_req        = req_valid && req_ready;
   assign ld_rd         = (st_q == ST_RD_WAIT) && mem_rdata_valid;
   assign ld_mrg        = (st_q == ST_MERGE);
   assign mem_cmd_valid = (st_q == ST_RD_ISSUE) || (st_q == ST_WR_ISSUE);
   assign mem_cmd_write = (st_q == ST_WR_ISSUE);
   assign mem_cmd_addr  = addr_q;
   assign wr_done       = (st_q == ST_DONE);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: begin
            if (ld_req) begin
               if (mask_none)    st_d = ST_DONE;
               else if (skip_rd) st_d = ST_WR_ISSUE;
               else              st_d = ST_RD_ISSUE;
            end
         end
         ST_RD_ISSUE: if (mem_cmd_ready) st_d = ST_RD_WAIT;
         ST_RD_WAIT:  if (mem_rdata_valid) st_d = ST_MERGE;
         ST_MERGE:    st_d = ST_WR_ISSUE;
         ST_WR_ISSUE: if (mem_cmd_ready) st_d = ST_DONE;
         ST_DONE:     st_d = ST_IDLE;
         default:     st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         addr_q <= '0;
         cap_be <= '0;
      end else begin
         st_q <= st_d;
         if (ld_req) begin
            addr_q <= req_addr;
            cap_be <= req_be;
         end
      end
   end

   // Address of the fetch of the running sequence, for the store-back check.
   logic [ADDR_W-1:0] rd_addr_seen;
   logic              rd_seen;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_addr_seen <= '0;
         rd_seen      <= 1'b0;
      end else if (mem_cmd_valid && mem_cmd_ready && !mem_cmd_write) begin
         rd_addr_seen <= mem_cmd_addr;
         rd_seen      <= 1'b1;
      end else if (wr_done) begin
         rd_seen      <= 1'b0;
      end
   end

   p_wb_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd_valid && mem_cmd_write && rd_seen) |-> (mem_cmd_addr == rd_addr_seen));

   p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_zero_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (req_be == '0)) |=> (wr_done && !mem_cmd_valid));

   p_full_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (FULL_BYPASS && req_valid && req_ready && (&req_be)) |=> (mem_cmd_valid && mem_cmd_write));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done);

   p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd_valid && !mem_cmd_ready) |=>
         (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_write)));
endmodule

// File: rtl/rmw_engine.sv
module rmw_engine #(
   parameter int ADDR_W      = 32,
   parameter int LANE_W      = 8,
   parameter int NUM_LANES   = 8,
   parameter bit FULL_BYPASS = 1'b1,
   localparam int DATA_W     = LANE_W * NUM_LANES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_data,
   input  logic [NUM_LANES-1:0] req_be,
   output logic                 mem_cmd_valid,
   input  logic                 mem_cmd_ready,
   output logic                 mem_cmd_write,
   output logic [ADDR_W-1:0]    mem_cmd_addr,
   output logic [DATA_W-1:0]    mem_wdata,
   input  logic                 mem_rdata_valid,
   input  logic [DATA_W-1:0]    mem_rdata,
   output logic                 wr_done
);
   generate
      if (LANE_W < 1 || NUM_LANES < 1) begin : g_bad_geom
         $error("rmw_engine: lane width and lane count must be positive");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("rmw_engine: address width must be positive");
      end
   endgenerate

   logic [NUM_LANES-1:0] cap_be;
   logic                 ld_req, ld_rd, ld_mrg;
   logic [DATA_W-1:0]    work_q, new_q, merged;

   rmw_ctrl #(
      .ADDR_W      (ADDR_W),
      .NUM_LANES   (NUM_LANES),
      .FULL_BYPASS (FULL_BYPASS)
   ) u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .req_valid       (req_valid),
      .req_ready       (req_ready),
      .req_addr        (req_addr),
      .req_be          (req_be),
      .cap_be          (cap_be),
      .mem_cmd_valid   (mem_cmd_valid),
      .mem_cmd_ready   (mem_cmd_ready),
      .mem_cmd_write   (mem_cmd_write),
      .mem_cmd_addr    (mem_cmd_addr),
      .mem_rdata_valid (mem_rdata_valid),
      .wr_done         (wr_done),
      .ld_req          (ld_req),
      .ld_rd           (ld_rd),
      .ld_mrg          (ld_mrg)
   );

   rmw_qbuf #(.DATA_W(DATA_W)) u_qbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_req   (ld_req),
      .ld_rd    (ld_rd),
      .ld_mrg   (ld_mrg),
      .req_data (req_data),
      .rd_data  (mem_rdata),
      .mrg_data (merged),
      .work_q   (work_q),
      .new_q    (new_q)
   );

   rmw_lane_merge #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_merge (
      .old_q   (work_q),
      .new_q   (new_q),
      .lane_en (cap_be),
      .merged  (merged)
   );

   assign mem_wdata = work_q;
endmodule

// File: tb/sim_rmw_engine.sv
module sim_rmw_engine;
   localparam int AW  = 32;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [63:0] req_data = '0;
   logic [7:0]  req_be = '0;
   logic        mem_cmd_valid, mem_cmd_ready, mem_cmd_write;
   logic [AW-1:0] mem_cmd_addr;
   logic [63:0] mem_wdata;
   logic        mem_rdata_valid = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        wr_done;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   rmw_engine u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_data(req_data), .req_be(req_be),
      .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
      .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr),
      .mem_wdata(mem_wdata), .mem_rdata_valid(mem_rdata_valid),
      .mem_rdata(mem_rdata), .wr_done(wr_done)
   );

   // memory model: 16 quadwords, stalling command port, fixed read latency
   logic [63:0] mem [0:15];
   logic [63:0] ref_mem [0:15];
   int cyc_ctr = 0;
   int rd_n = 0, wr_n = 0, rd_cnt = 0;
   logic [3:0] rd_idx = '0;

   function automatic logic [63:0] init_word(input int i);
      return 64'hC3C3_0000_5A5A_0000 ^ (64'(i) * 64'h0011_2233_4455_6677);
   endfunction

   function automatic logic [63:0] lane_mix(input logic [63:0] o, input logic [63:0] n,
                                            input logic [7:0] b);
      logic [63:0] r;
      for (int i = 0; i < 8; i++) r[i*8 +: 8] = b[i] ? n[i*8 +: 8] : o[i*8 +: 8];
      return r;
   endfunction

   assign mem_cmd_ready = (cyc_ctr % 5) != 3;

   always @(posedge clk) begin
      cyc_ctr <= cyc_ctr + 1;
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
         rd_cnt <= 0;
         mem_rdata_valid <= 1'b0;
      end else begin
         if (mem_cmd_valid && mem_cmd_ready) begin
            if (mem_cmd_write) begin
               mem[mem_cmd_addr[3:0]] <= mem_wdata;
               wr_n <= wr_n + 1;
            end else begin
               rd_idx <= mem_cmd_addr[3:0];
               rd_cnt <= LAT;
               rd_n <= rd_n + 1;
            end
         end else if (rd_cnt > 0) begin
            rd_cnt <= rd_cnt - 1;
         end
         mem_rdata_valid <= (rd_cnt == 1);
         mem_rdata <= (rd_cnt == 1) ? mem[rd_idx] : 64'hBAD0_BAD0_BAD0_BAD0;
      end
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   // R9 monitor: a stalled command must hold into the next cycle
   logic          h_pend = 1'b0;
   logic [AW-1:0] h_addr;
   logic          h_wr;
   always @(negedge clk) begin
      if (rst_n) begin
         if (h_pend) begin
            chk(mem_cmd_valid && mem_cmd_addr == h_addr && mem_cmd_write == h_wr,
                "R9", "stalled command held", {31'b0, mem_cmd_write, mem_cmd_addr},
                {31'b0, h_wr, h_addr});
         end
         h_pend = mem_cmd_valid && !mem_cmd_ready;
         h_addr = mem_cmd_addr;
         h_wr   = mem_cmd_write;
      end
   end

   // One request; if chain is set the next request is left on the port.
   task automatic run_req(input logic [3:0] a, input logic [63:0] d, input logic [7:0] b,
                          input bit chain, input logic [3:0] na,
                          input logic [63:0] nd, input logic [7:0] nb);
      int rd0, wr0, cyc, dones;
      bit bad_ready;
      @(negedge clk);
      req_valid = 1'b1; req_addr = AW'(a); req_data = d; req_be = b;
      while (!req_ready) @(negedge clk);
      rd0 = rd_n; wr0 = wr_n;
      @(negedge clk);
      if (chain) begin
         req_addr = AW'(na); req_data = nd; req_be = nb;
      end else begin
         req_valid = 1'b0;
      end
      ref_mem[a] = lane_mix(ref_mem[a], d, b);
      cyc = 1; bad_ready = 1'b0;
      while (!wr_done && cyc < 200) begin
         if (req_ready) bad_ready = 1'b1;
         @(negedge clk);
         cyc++;
      end
      chk(!bad_ready && !req_ready && wr_done, "R7", "ready low until done",
          {63'b0, bad_ready}, 64'd0);
      if (b == 8'h00)
         chk(cyc == 1, "R6", "empty mask done latency", 64'(cyc), 64'd1);
      chk(mem[a] == ref_mem[a], (b == 8'hFF || b == 8'h00) ? "R5" : "R3",
          $sformatf("merged word mask %h", b), mem[a], ref_mem[a]);
      chk(rd_n - rd0 == ((b != 8'h00 && b != 8'hFF) ? 1 : 0), "R2",
          $sformatf("read count mask %h", b), 64'(rd_n - rd0),
          (b != 8'h00 && b != 8'hFF) ? 64'd1 : 64'd0);
      chk(wr_n - wr0 == ((b != 8'h00) ? 1 : 0), "R1",
          $sformatf("write count mask %h", b), 64'(wr_n - wr0),
          (b != 8'h00) ? 64'd1 : 64'd0);
      @(negedge clk);
      dones = 0;
      if (wr_done) dones++;
      chk(dones == 0, "R8", "done is one cycle", 64'(dones), 64'd0);
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) ref_mem[i] = init_word(i);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R10", "ready after reset", {63'b0, req_ready}, 64'd1);
      chk(mem_cmd_valid == 1'b0, "R10", "no command after reset", {63'b0, mem_cmd_valid}, 64'd0);
      chk(wr_done == 1'b0, "R10", "no done after reset", {63'b0, wr_done}, 64'd0);

      // R4: every mask, including non-adjacent lane patterns
      for (int m = 0; m < 256; m++) begin
         run_req(4'(m), {8{8'(m)}} ^ 64'h0F1E_2D3C_4B5A_6978, 8'(m), 1'b0, 4'd0, 64'd0, 8'd0);
      end

      // R4 spot masks on one quadword, sparse patterns
      run_req(4'd7, 64'h1111_2222_3333_4444, 8'b1010_0101, 1'b0, 4'd0, 64'd0, 8'd0);
      run_req(4'd7, 64'h9999_8888_7777_6666, 8'b0100_0010, 1'b0, 4'd0, 64'd0, 8'd0);

      // R7: back-to-back overlapping writes to one quadword, second held on the port
      run_req(4'd3, 64'hAAAA_AAAA_AAAA_AAAA, 8'b0000_1111, 1'b1,
              4'd3, 64'h5555_5555_5555_5555, 8'b0011_1100);
      run_req(4'd3, 64'h5555_5555_5555_5555, 8'b0011_1100, 1'b0, 4'd0, 64'd0, 8'd0);

      // R6 then R5 chained, zero mask followed by full mask
      run_req(4'd9, 64'hFFFF_0000_FFFF_0000, 8'h00, 1'b1, 4'd9, 64'h0123_4567_89AB_CDEF, 8'hFF);
      run_req(4'd9, 64'h0123_4567_89AB_CDEF, 8'hFF, 1'b0, 4'd0, 64'd0, 8'd0);

      for (int i = 0; i < 16; i++)
         chk(mem[i] == ref_mem[i], "R4", $sformatf("final word %0d", i), mem[i], ref_mem[i]);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule